// File: doc/BRIEF.md
# Descriptor-Chained XOR Accumulate Engine

This block moves and combines data between memory buffers without processor involvement. Software builds a linked list of descriptors in memory. Each descriptor names up to four source buffers, a destination buffer, a byte count and a control word. Software then writes the address of the first descriptor and sets the enable bit. For every 32-bit word position, the engine starts an accumulator at zero and applies each source's own block command in order, source 1 to source 4. It then stores the accumulator to the destination, unless the control word withholds the write.

When a descriptor finishes, the engine raises end-of-transfer and follows the descriptor's link word. A zero link stops the walk and raises end-of-chain. Software may later patch the link word of the last descriptor and request a chain resume. The engine then re-reads that word and carries on. Memory is reached through a single-outstanding 32-bit word request/response port. An error response aborts the run and sets a master-abort flag.

Top module: `xor_chain_engine`

## Requirements
- R1: After reset, every readable register returns 0, `irq` is 0 and no memory request is issued.
- R2: A descriptor is eight consecutive words at its pointer: link, source 1 to 4 addresses, destination address, byte count, control. The low five bits of every descriptor pointer are ignored.
- R3: Only bits [23:0] of the count word are used. The number of words moved is that count shifted right by two. A count of zero moves nothing but still completes the descriptor.
- R4: Control bits [3:1], [6:4], [9:7] and [12:10] give the commands of sources 1 to 4. Code 1 XORs the source word into the accumulator. Code 2 loads the source's address field itself as a constant pattern. Code 7 loads the source word. Code 0 and all other codes leave the accumulator untouched. Sources apply in order 1 to 4 from an accumulator of 0.
- R5: When control bit 31 is 0, no write reaches memory and the destination is unchanged.
- R6: After a descriptor whose link (low five bits ignored) is zero, status bit 8 (end of chain) sets and status bit 10 (active) clears. Otherwise the next descriptor is processed.
- R7: Status bit 9 (end of transfer) sets after each completed descriptor. `irq` is the registered OR of three terms: bit 9 when the last completed descriptor had control bit 0 set, bit 8, and bit 5.
- R8: Writing 0x3 to control (offset 0x00) while idle makes the engine re-read the link word of the last descriptor and continue from there.
- R9: Status (offset 0x04) bits 5, 8 and 9 clear when written with 1. Bit 10 reads 1 while the engine is running.
- R10: An error response on the memory port sets status bit 5, stops the engine and raises `irq`.
- R11: Offsets 0x08, 0x0C, 0x20, 0x24 and 0x28 read back the current descriptor pointer, link, destination, 24-bit count and control word. Read data appears one cycle after the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for `reg_addr` |
| mem_req | output | 1 | One-cycle memory request pulse |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_rvalid | input | 1 | Response to the outstanding request |
| mem_err | input | 1 | Response carries an error |
| mem_rdata | input | 32 | Read response data |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume a well-behaved environment. The memory answers each request with exactly one response, and at least one cycle after it. Software issues no control write in the cycle right after the engine goes idle, and writes the link register only while the engine is inactive. The stimulus meets these conditions in three ways. The bench memory always replies on the following falling edge. Each run is started only after the interrupt has been seen and the status cleared. All register accesses are made from tasks that wait for idle.

// File: rtl/xce_pkg.sv
package xce_pkg;
  localparam int NSRC = 4;
  localparam int DESC_WORDS = 8;

  localparam logic [2:0] CMD_NULL = 3'd0;
  localparam logic [2:0] CMD_XOR  = 3'd1;
  localparam logic [2:0] CMD_FILL = 3'd2;
  localparam logic [2:0] CMD_COPY = 3'd7;

  localparam logic [5:0] OFS_CTRL = 6'h00;
  localparam logic [5:0] OFS_STAT = 6'h04;
  localparam logic [5:0] OFS_CUR  = 6'h08;
  localparam logic [5:0] OFS_LINK = 6'h0C;
  localparam logic [5:0] OFS_DST  = 6'h20;
  localparam logic [5:0] OFS_CNT  = 6'h24;
  localparam logic [5:0] OFS_CTL  = 6'h28;

  localparam int ST_MA  = 5;
  localparam int ST_EOC = 8;
  localparam int ST_EOT = 9;
  localparam int ST_ACT = 10;

  typedef enum logic [2:0] {
    S_IDLE, S_LINK, S_CHECK, S_FETCH, S_NEXT, S_SRC, S_WRITE
  } seq_state_t;
endpackage

// File: rtl/xce_combine.sv
module xce_combine #(
  parameter int DW = 32
) (
  input  logic [2:0]    cmd,
  input  logic [DW-1:0] acc_in,
  input  logic [DW-1:0] mem_word,
  input  logic [DW-1:0] pattern,
  output logic [DW-1:0] acc_out,
  output logic          needs_read
);
  import xce_pkg::*;

  always_comb begin
    needs_read = (cmd == CMD_XOR) || (cmd == CMD_COPY);
    case (cmd)
      CMD_XOR:  acc_out = acc_in ^ mem_word;
      CMD_FILL: acc_out = pattern;
      CMD_COPY: acc_out = mem_word;
      default:  acc_out = acc_in;
    endcase
  end
endmodule

// File: rtl/xce_seq.sv
module xce_seq #(
  parameter int DW = 32,
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          resume,
  input  logic          sw_link_we,
  input  logic [DW-1:0] sw_link,
  output logic          mem_req,
  output logic          mem_we,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_rvalid,
  input  logic          mem_err,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic [DW-1:0] cur_desc,
  output logic [DW-1:0] link_q,
  output logic [DW-1:0] dst_q,
  output logic [CW-1:0] cnt_q,
  output logic [DW-1:0] ctl_q,
  output logic          eot_p,
  output logic          eoc_p,
  output logic          abort_p
);
  import xce_pkg::*;

  localparam int WW  = CW - 2;
  localparam int SIW = $clog2(NSRC);
  localparam int FIW = $clog2(DESC_WORDS);

  seq_state_t         st;
  logic               pend;
  logic [FIW-1:0]     fidx;
  logic [SIW-1:0]     sidx;
  logic [WW-1:0]      widx;
  logic [DW-1:0]      acc;
  logic [DW-1:0]      sar [NSRC];
  logic [2:0]         cur_cmd;
  logic [DW-1:0]      acc_nxt;
  logic               needs_rd;
  logic [DW-1:0]      woff;

  assign busy    = (st != S_IDLE);
  assign cur_cmd = ctl_q[1 + 3*sidx +: 3];
  assign woff    = {{(DW-CW){1'b0}}, widx, 2'b00};

  xce_combine #(.DW(DW)) u_comb (
    .cmd(cur_cmd), .acc_in(acc), .mem_word(mem_rdata), .pattern(sar[sidx]),
    .acc_out(acc_nxt), .needs_read(needs_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; pend <= 1'b0; fidx <= '0; sidx <= '0; widx <= '0;
      acc <= '0; cur_desc <= '0; link_q <= '0; dst_q <= '0; cnt_q <= '0;
      ctl_q <= '0; mem_req <= 1'b0; mem_we <= 1'b0; mem_addr <= '0;
      mem_wdata <= '0; eot_p <= 1'b0; eoc_p <= 1'b0; abort_p <= 1'b0;
      for (int i = 0; i < NSRC; i++) sar[i] <= '0;
    end else begin
      mem_req <= 1'b0;
      eot_p   <= 1'b0;
      eoc_p   <= 1'b0;
      abort_p <= 1'b0;
      if (pend && mem_rvalid) pend <= 1'b0;
      if (pend && mem_rvalid && mem_err) begin
        abort_p <= 1'b1;
        st      <= S_IDLE;
      end else begin
        case (st)
          S_IDLE: begin
            if (sw_link_we) link_q <= sw_link;
            if (resume) st <= S_LINK;
            else if (start) st <= S_CHECK;
          end
          S_LINK: begin
            if (!pend) begin
              mem_req <= 1'b1; mem_we <= 1'b0; mem_addr <= cur_desc; pend <= 1'b1;
            end else if (mem_rvalid) begin
              link_q <= mem_rdata;
              st     <= S_CHECK;
            end
          end
          S_CHECK: begin
            if (link_q[DW-1:5] == '0) begin
              eoc_p <= 1'b1;
              st    <= S_IDLE;
            end else begin
              cur_desc <= {link_q[DW-1:5], 5'b0};
              fidx     <= '0;
              st       <= S_FETCH;
            end
          end
          S_FETCH: begin
            if (!pend) begin
              mem_req <= 1'b1; mem_we <= 1'b0; pend <= 1'b1;
              mem_addr <= cur_desc + {{(DW-FIW-2){1'b0}}, fidx, 2'b00};
            end else if (mem_rvalid) begin
              case (fidx)
                3'd0: link_q <= mem_rdata;
                3'd5: dst_q  <= mem_rdata;
                3'd6: cnt_q  <= mem_rdata[CW-1:0];
                3'd7: ctl_q  <= mem_rdata;
                default: sar[SIW'(fidx - 3'd1)] <= mem_rdata;
              endcase
              fidx <= fidx + 1'b1;
              if (fidx == FIW'(DESC_WORDS - 1)) begin
                widx <= '0;
                st   <= S_NEXT;
              end
            end
          end
          S_NEXT: begin
            if (widx == cnt_q[CW-1:2]) begin
              eot_p <= 1'b1;
              st    <= S_CHECK;
            end else begin
              sidx <= '0;
              acc  <= '0;
              st   <= S_SRC;
            end
          end
          S_SRC: begin
            if (needs_rd && !pend) begin
              mem_req <= 1'b1; mem_we <= 1'b0; pend <= 1'b1;
              mem_addr <= sar[sidx] + woff;
            end else if (!needs_rd || mem_rvalid) begin
              acc <= acc_nxt;
              if (sidx == SIW'(NSRC - 1)) st <= S_WRITE;
              else sidx <= sidx + 1'b1;
            end
          end
          S_WRITE: begin
            if (!ctl_q[DW-1]) begin
              widx <= widx + 1'b1;
              st   <= S_NEXT;
            end else if (!pend) begin
              mem_req <= 1'b1; mem_we <= 1'b1; pend <= 1'b1;
              mem_addr <= dst_q + woff; mem_wdata <= acc;
            end else if (mem_rvalid) begin
              widx <= widx + 1'b1;
              st   <= S_NEXT;
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/xor_chain_engine.sv
module xor_chain_engine #(
  parameter int DW  = 32,
  parameter int RAW = 6,
  parameter int CW  = 24
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           reg_we,
  input  logic [RAW-1:0] reg_addr,
  input  logic [DW-1:0]  reg_wdata,
  output logic [DW-1:0]  reg_rdata,
  output logic           mem_req,
  output logic           mem_we,
  output logic [DW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  input  logic           mem_rvalid,
  input  logic           mem_err,
  input  logic [DW-1:0]  mem_rdata,
  output logic           irq
);
  import xce_pkg::*;

  logic          busy, en_q;
  logic          st_eot, st_eoc, st_ma, st_ie;
  logic          eot_p, eoc_p, abort_p;
  logic          ctrl_wr, stat_wr, start, resume, link_we;
  logic [DW-1:0] cur_desc, link_q, dst_q, ctl_q;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] status;

  assign ctrl_wr = reg_we && (reg_addr == RAW'(OFS_CTRL));
  assign stat_wr = reg_we && (reg_addr == RAW'(OFS_STAT));
  assign start   = ctrl_wr && reg_wdata[0] && !busy;
  assign resume  = start && reg_wdata[1];
  assign link_we = reg_we && (reg_addr == RAW'(OFS_LINK)) && !busy;

  xce_seq #(.DW(DW), .CW(CW)) u_seq (
    .clk(clk), .rst(rst), .start(start), .resume(resume),
    .sw_link_we(link_we), .sw_link(reg_wdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rvalid(mem_rvalid), .mem_err(mem_err), .mem_rdata(mem_rdata),
    .busy(busy), .cur_desc(cur_desc), .link_q(link_q), .dst_q(dst_q),
    .cnt_q(cnt_q), .ctl_q(ctl_q), .eot_p(eot_p), .eoc_p(eoc_p), .abort_p(abort_p)
  );

  always_comb begin
    status         = '0;
    status[ST_MA]  = st_ma;
    status[ST_EOC] = st_eoc;
    status[ST_EOT] = st_eot;
    status[ST_ACT] = busy;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= 1'b0; st_eot <= 1'b0; st_eoc <= 1'b0; st_ma <= 1'b0; st_ie <= 1'b0;
      irq <= 1'b0; reg_rdata <= '0;
    end else begin
      if (ctrl_wr) en_q <= reg_wdata[0];
      if (stat_wr) begin
        if (reg_wdata[ST_EOT]) st_eot <= 1'b0;
        if (reg_wdata[ST_EOC]) st_eoc <= 1'b0;
        if (reg_wdata[ST_MA])  st_ma  <= 1'b0;
      end
      if (eot_p) begin
        st_eot <= 1'b1;
        st_ie  <= ctl_q[0];
      end
      if (eoc_p)   st_eoc <= 1'b1;
      if (abort_p) st_ma  <= 1'b1;
      irq <= (st_eot && st_ie) || st_eoc || st_ma;
      case (reg_addr)
        RAW'(OFS_CTRL): reg_rdata <= {{(DW-1){1'b0}}, en_q};
        RAW'(OFS_STAT): reg_rdata <= status;
        RAW'(OFS_CUR):  reg_rdata <= cur_desc;
        RAW'(OFS_LINK): reg_rdata <= link_q;
        RAW'(OFS_DST):  reg_rdata <= dst_q;
        RAW'(OFS_CNT):  reg_rdata <= {{(DW-CW){1'b0}}, cnt_q};
        RAW'(OFS_CTL):  reg_rdata <= ctl_q;
        default:        reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/xce_checker.sv
module xce_checker (
  input logic clk,
  input logic rst,
  input logic mem_req,
  input logic mem_we,
  input logic busy,
  input logic dwe,
  input logic st_eot,
  input logic st_ie,
  input logic st_eoc,
  input logic st_ma,
  input logic irq
);
  p_req_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req);

  p_write_gate_r5: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> dwe);

  p_irq_cause_r7: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past((st_eot && st_ie) || st_eoc || st_ma));

  p_eoc_idle_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(st_eoc) |-> !busy);

  p_abort_idle_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(st_ma) |-> !busy);

  p_idle_no_req_r1: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(busy)) |-> !mem_req);
endmodule

bind xor_chain_engine xce_checker u_chk (
  .clk(clk), .rst(rst), .mem_req(mem_req), .mem_we(mem_we), .busy(busy),
  .dwe(ctl_q[31]), .st_eot(st_eot), .st_ie(st_ie), .st_eoc(st_eoc),
  .st_ma(st_ma), .irq(irq)
);

// File: tb/xor_chain_engine_bench.sv
`timescale 1ns/1ps
module xor_chain_engine_bench;
  logic        clk = 0, rst = 1;
  logic        reg_we = 0;
  logic [5:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        mem_req, mem_we, irq;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_rvalid = 0, mem_err = 0;
  logic [31:0] mem_rdata = 0;
  logic [31:0] mem [0:1023];
  int total = 0, bad = 0, cyc = 0;

  always #4 clk = ~clk;

  xor_chain_engine u_xor_chain_engine (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rvalid(mem_rvalid), .mem_err(mem_err), .mem_rdata(mem_rdata), .irq(irq)
  );

  // bench memory: replies on the falling edge after each request
  always @(negedge clk) begin
    mem_rvalid <= 1'b0;
    mem_err    <= 1'b0;
    if (mem_req) begin
      mem_rvalid <= 1'b1;
      if (mem_addr[31:12] != 0) mem_err <= 1'b1;
      else if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
      else mem_rdata <= mem[mem_addr[11:2]];
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d cycles expected=<190000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic reg_read(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a;
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic wait_irq();
    for (int i = 0; i < 3000 && !irq; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic put_desc(input int base, input logic [31:0] lnk, input logic [31:0] s0,
                          input logic [31:0] s1, input logic [31:0] s2, input logic [31:0] s3,
                          input logic [31:0] dst, input logic [31:0] cnt, input logic [31:0] ctl);
    mem[base/4+0] = lnk; mem[base/4+1] = s0; mem[base/4+2] = s1; mem[base/4+3] = s2;
    mem[base/4+4] = s3;  mem[base/4+5] = dst; mem[base/4+6] = cnt; mem[base/4+7] = ctl;
  endtask

  task automatic run(input logic [31:0] first);
    reg_write(6'h04, 32'hFFFF_FFFF);
    reg_write(6'h0C, first);
    reg_write(6'h00, 32'h1);
    wait_irq();
  endtask

  function automatic logic [31:0] srcval(input int s, input int w, input int c);
    return 32'hA500_0000 ^ (32'(s) << 20) ^ (32'(w) * 32'h0003_0307) ^ (32'(c) << 8);
  endfunction

  function automatic logic [31:0] sar(input int s);
    return 32'h400 + 32'(s) * 32'h100;
  endfunction

  initial begin
    logic [31:0] rd;
    logic [2:0]  cd [4];
    logic [31:0] ctl, exp_w;
    for (int i = 0; i < 1024; i++) mem[i] = 0;
    repeat (3) @(negedge clk);
    rst = 0;

    // R1 reset state
    reg_read(6'h00, rd); check("R1 ctrl", rd, 0);
    reg_read(6'h04, rd); check("R1 status", rd, 0);
    reg_read(6'h0C, rd); check("R1 link", rd, 0);
    check("R1 irq", {31'b0, irq}, 0);

    // R4 R2 R3: sweep over all command combinations {0,1,2,7}^4
    for (int c = 0; c < 256; c++) begin
      ctl = 32'h8000_0001;
      for (int s = 0; s < 4; s++) begin
        case ((c >> (2*s)) & 3)
          0: cd[s] = 3'd0;
          1: cd[s] = 3'd1;
          2: cd[s] = 3'd2;
          default: cd[s] = 3'd7;
        endcase
        ctl |= 32'(cd[s]) << (1 + 3*s);
        for (int w = 0; w < 3; w++) mem[sar(s)/4 + w] = srcval(s, w, c);
      end
      for (int w = 0; w < 4; w++) mem[32'h800/4 + w] = 32'hDEAD_BEEF;
      put_desc(32'h100, 32'h0, sar(0), sar(1), sar(2), sar(3), 32'h800, 32'hAB00_000C, ctl);
      run(32'h113);
      for (int w = 0; w < 3; w++) begin
        exp_w = 0;
        for (int s = 0; s < 4; s++)
          case (cd[s])
            3'd1: exp_w ^= srcval(s, w, c);
            3'd2: exp_w = sar(s);
            3'd7: exp_w = srcval(s, w, c);
            default: ;
          endcase
        check("R4 combine word", mem[32'h800/4 + w], exp_w);
      end
      check("R3 count ignores upper byte", mem[32'h800/4 + 3], 32'hDEAD_BEEF);
      reg_read(6'h04, rd); check("R2 status after run", rd, 32'h300);
    end

    // R4 unlisted codes behave as null
    for (int w = 0; w < 2; w++) mem[32'h800/4 + w] = 0;
    put_desc(32'h100, 0, sar(0), sar(1), sar(2), sar(3), 32'h800, 8,
             32'h8000_0001 | (7 << 1) | (3 << 4) | (5 << 7) | (6 << 10));
    run(32'h100);
    check("R4 unlisted code null", mem[32'h800/4], srcval(0, 0, 255));
    check("R4 unlisted code null w1", mem[32'h800/4 + 1], srcval(0, 1, 255));

    // R5 write disabled
    for (int w = 0; w < 2; w++) mem[32'h800/4 + w] = 32'h1234_5678;
    put_desc(32'h100, 0, sar(0), 0, 0, 0, 32'h800, 8, 32'h0000_0001 | (7 << 1));
    run(32'h100);
    check("R5 no write", mem[32'h800/4], 32'h1234_5678);
    reg_read(6'h04, rd); check("R5 still completes", rd, 32'h300);

    // R3 zero count
    put_desc(32'h100, 0, sar(0), 0, 0, 0, 32'h800, 32'hFF00_0000, 32'h8000_0001 | (7 << 1));
    run(32'h100);
    check("R3 zero count no write", mem[32'h800/4], 32'h1234_5678);
    reg_read(6'h04, rd); check("R3 zero count completes", rd, 32'h300);

    // R7 interrupt gating by control bit 0
    put_desc(32'h100, 0, sar(0), 0, 0, 0, 32'h800, 4, 32'h8000_0000 | (7 << 1));
    run(32'h100);
    reg_write(6'h04, 32'h100); @(negedge clk); @(negedge clk);
    check("R7 irq off when ie clear", {31'b0, irq}, 0);
    reg_read(6'h04, rd); check("R9 W1C leaves other flag", rd, 32'h200);
    put_desc(32'h100, 0, sar(0), 0, 0, 0, 32'h800, 4, 32'h8000_0001 | (7 << 1));
    run(32'h100);
    reg_write(6'h04, 32'h100); @(negedge clk); @(negedge clk);
    check("R7 irq on when ie set", {31'b0, irq}, 1);
    reg_write(6'h04, 32'h200); @(negedge clk); @(negedge clk);
    check("R9 W1C clears irq", {31'b0, irq}, 0);

    // R6 three-descriptor chain
    put_desc(32'h100, 32'h140, sar(0), 0, 0, 0, 32'h900, 8, 32'h8000_0000 | (7 << 1));
    put_desc(32'h140, 32'h18F, sar(1), 0, 0, 0, 32'h940, 8, 32'h8000_0000 | (7 << 1));
    put_desc(32'h180, 32'h01F, sar(2), 0, 0, 0, 32'h980, 32'h7700_0008, 32'h8000_0001 | (7 << 1));
    run(32'h100);
    for (int d = 0; d < 3; d++)
      for (int w = 0; w < 2; w++)
        check("R6 chain dest", mem[(32'h900 + 32'(d) * 32'h40)/4 + w], mem[sar(d)/4 + w]);
    reg_read(6'h04, rd); check("R6 end of chain idle", rd, 32'h300);
    reg_read(6'h08, rd); check("R11 current desc", rd, 32'h180);
    reg_read(6'h0C, rd); check("R11 link", rd, 32'h01F);
    reg_read(6'h20, rd); check("R11 dest", rd, 32'h980);
    reg_read(6'h24, rd); check("R11 count", rd, 32'h8);
    reg_read(6'h28, rd); check("R11 control", rd, 32'h8000_000F);

    // R8 chain resume
    mem[32'h180/4] = 32'h1C0;
    put_desc(32'h1C0, 0, sar(3), 0, 0, 0, 32'hA00, 4, 32'h8000_0001 | (7 << 1));
    reg_write(6'h04, 32'hFFFF_FFFF);
    reg_write(6'h00, 32'h3);
    wait_irq();
    check("R8 resume dest", mem[32'hA00/4], mem[sar(3)/4]);
    reg_read(6'h08, rd); check("R8 resume current", rd, 32'h1C0);

    // R9 active bit during a long run
    put_desc(32'h100, 0, sar(0), 0, 0, 0, 32'hC00, 256, 32'h8000_0001 | (1 << 1));
    reg_write(6'h04, 32'hFFFF_FFFF);
    reg_write(6'h0C, 32'h100);
    reg_write(6'h00, 32'h1);
    reg_read(6'h04, rd); check("R9 active while running", rd, 32'h400);
    wait_irq();
    reg_read(6'h04, rd); check("R9 inactive after", rd, 32'h300);
    check("R4 xor last word", mem[32'hC00/4 + 63], mem[sar(0)/4 + 63]);

    // R10 master abort
    put_desc(32'h100, 32'h140, 32'h0001_0000, 0, 0, 0, 32'h800, 8, 32'h8000_0001 | (1 << 1));
    run(32'h100);
    reg_read(6'h04, rd); check("R10 abort status", rd, 32'h20);
    check("R10 abort irq", {31'b0, irq}, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule